// File: doc/BRIEF.md
# Dual-Role Parallel Port Controller

This block owns one 8-bit group of bidirectional pads and gives it two personalities chosen by a mode input. In single-chip mode the group is a general-purpose I/O port. It has an output register, a per-pin direction register and a port-wide open-drain switch. It also has a capture register that grabs the pin levels when a strobe input makes a chosen transition. In expanded mode the same pads form a multiplexed bus. While the bus-phase clock E is low they drive the low byte of the address. While E is high they carry data, either out (write) or in (read).

Software reaches the port through a small synchronous register bus with a two-bit select. The pad ring sees three per-pin vectors: output value, output enable and input level. The analog drivers and pull-ups sit outside the block. In expanded mode, read data reaches the bus side on a separate output that is loaded when E falls.

Top module: `muxport_ctrl`

## Requirements
- R1: After reset the direction register is 0 (all inputs), the control register is 0 (open-drain off, strobe polarity falling) and the capture register is 0, so in single-chip mode pad_oe is 0.
- R2: Register select 1 reads and writes the direction register. Select 2 reads and writes the control register: bit 0 is open-drain enable and bit 1 is strobe polarity (1 = rising, 0 = falling); the other bits read 0. Select 3 reads the capture register and ignores writes. A write to select 0 loads the output register.
- R3: In single-chip mode with open-drain off, pad_out equals the output register and pad_oe equals the direction register.
- R4: In single-chip mode with open-drain on, pad_out equals the output register, and pad_oe bit i is direction bit i AND NOT output bit i, so a 1 releases the pin.
- R5: A strobe transition of the polarity selected in control bit 1 loads the pad inputs into the capture register within four clock cycles. A transition of the other polarity leaves the register unchanged.
- R6: In expanded mode with E low, pad_out equals the low address byte and pad_oe is all ones.
- R7: In expanded mode with E high and R/W low (write), pad_out equals the bus write data and pad_oe is all ones.
- R8: In expanded mode with E high and R/W high (read), pad_oe is all zeros. The pin levels seen during that phase appear on bus_rdata after E falls, and bus_rdata holds until the next read phase ends.
- R9: The open-drain bit has no effect on pad_out or pad_oe in expanded mode.
- R10: A read of register select 0 returns the live pad input levels, not the capture register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| mode_exp | input | 1 | 1 = expanded bus mode, 0 = single-chip I/O |
| bus_e | input | 1 | Bus phase clock, high = data phase |
| bus_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr_lo | input | 8 | Low address byte for the address phase |
| bus_wdata | input | 8 | Data to drive on a bus write |
| bus_rdata | output | 8 | Data captured on a bus read |
| strobe_a | input | 1 | Asynchronous capture strobe |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |

## Verification
The bench sweeps many direction and output register pairs in both drive styles. An enable term with the wrong polarity, or an open-drain term applied to all bits at once, would show up as a wrong pad_oe bit. In expanded mode it repeats the sweeps with open-drain set, which exposes a design that lets the single-chip drive style leak onto the bus. On the strobe it drives both edges under both polarities. A detector that reacts to either edge, or that has the polarity reversed, either overwrites the captured byte or never loads it. On bus reads it checks that bus_rdata stays put while E is high and updates only after the fall. A design that samples on the wrong edge or follows the pins live fails those checks.

// File: rtl/muxport_pkg.sv
package muxport_pkg;
  typedef enum logic [1:0] {
    SEL_PINS  = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_LATCH = 2'd3
  } sel_e;

  localparam int CTRL_OD_BIT  = 0;
  localparam int CTRL_POL_BIT = 1;
  localparam int CTRL_BITS    = 2;
endpackage

// File: rtl/muxport_regs.sv
module muxport_regs
  import muxport_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] out_q,
  output logic [W-1:0] dir_q,
  output logic         od_q,
  output logic         pol_q
);
  logic [W-1:0] out_d, dir_d;
  logic         od_d, pol_d;

  always_comb begin
    out_d = out_q;
    dir_d = dir_q;
    od_d  = od_q;
    pol_d = pol_q;
    if (wr_en) begin
      unique case (sel_e'(wr_sel))
        SEL_PINS:  out_d = wr_data;
        SEL_DIR:   dir_d = wr_data;
        SEL_CTRL: begin
          od_d  = wr_data[CTRL_OD_BIT];
          pol_d = wr_data[CTRL_POL_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      dir_q <= '0;
      od_q  <= 1'b0;
      pol_q <= 1'b0;
    end else begin
      out_q <= out_d;
      dir_q <= dir_d;
      od_q  <= od_d;
      pol_q <= pol_d;
    end
  end

  // R2
  dir_write_only_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(dir_q) |-> $past(wr_en && wr_sel == 2'd1));
endmodule

// File: rtl/muxport_strobe.sv
module muxport_strobe #(
  parameter int W     = 8,
  parameter int SYNC_N = 2
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         strobe_i,
  input  logic         pol_i,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] latch_q
);
  localparam int HN = SYNC_N + 1;

  logic [HN-1:0] hist_q, hist_d;
  logic          rise, fall, hit;
  logic [W-1:0]  latch_d;

  always_comb begin
    hist_d  = {hist_q[HN-2:0], strobe_i};
    rise    = hist_q[HN-2] & ~hist_q[HN-1];
    fall    = ~hist_q[HN-2] & hist_q[HN-1];
    hit     = pol_i ? rise : fall;
    latch_d = hit ? pins_i : latch_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q  <= '0;
      latch_q <= '0;
    end else begin
      hist_q  <= hist_d;
      latch_q <= latch_d;
    end
  end

  // R5
  latch_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(latch_q) |-> $past(hist_q[HN-2] != hist_q[HN-1]));
endmodule

// File: rtl/muxport_padmux.sv
module muxport_padmux #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         mode_exp,
  input  logic         bus_e,
  input  logic         bus_rw,
  input  logic [W-1:0] addr_lo,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] out_q,
  input  logic [W-1:0] dir_q,
  input  logic         od_q,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  logic [W-1:0] gpio_oe;

  // Open-drain: a 1 bit keeps the pin released.
  always_comb begin
    gpio_oe = dir_q & ~({W{od_q}} & out_q);
    if (!mode_exp) begin
      pad_out = out_q;
      pad_oe  = gpio_oe;
    end else if (!bus_e) begin
      pad_out = addr_lo;
      pad_oe  = '1;
    end else if (bus_rw) begin
      pad_out = wdata;
      pad_oe  = '0;
    end else begin
      pad_out = wdata;
      pad_oe  = '1;
    end
  end

  // R4
  od_release_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!mode_exp && od_q) |-> ((pad_oe & out_q) == '0));
  // R8
  bus_read_hiz_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_exp && bus_e && bus_rw) |-> (pad_oe == '0));
  // R6
  addr_phase_drive_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_exp && !bus_e) |-> (pad_oe == '1 && pad_out == addr_lo));
endmodule

// File: rtl/muxport_busrd.sv
module muxport_busrd #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         mode_exp,
  input  logic         bus_e,
  input  logic         bus_rw,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] rdata_q
);
  logic         e_q, rw_q;
  logic [W-1:0] hold_q;
  logic         hold_en, fall_en;
  logic [W-1:0] hold_d, rdata_d;

  always_comb begin
    hold_en = mode_exp & bus_e & bus_rw;
    fall_en = mode_exp & e_q & ~bus_e & rw_q;
    hold_d  = hold_en ? pins_i : hold_q;
    rdata_d = fall_en ? hold_q : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      e_q     <= 1'b0;
      rw_q    <= 1'b0;
      hold_q  <= '0;
      rdata_q <= '0;
    end else begin
      e_q     <= bus_e;
      rw_q    <= bus_rw;
      hold_q  <= hold_d;
      rdata_q <= rdata_d;
    end
  end

  // R8
  rdata_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(rdata_q) |-> $past(mode_exp && !bus_e && e_q));
endmodule

// File: rtl/muxport_ctrl.sv
module muxport_ctrl
  import muxport_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   reg_sel,
  input  logic         reg_wr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         mode_exp,
  input  logic         bus_e,
  input  logic         bus_rw,
  input  logic [W-1:0] bus_addr_lo,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         strobe_a,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  logic [1:0]   rst_sync_q;
  logic         rst_ni;
  logic [W-1:0] out_q, dir_q, latch_q;
  logic         od_q, pol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  muxport_regs #(.W(W)) u_regs (
    .clk(clk), .rst_ni(rst_ni), .wr_en(reg_wr), .wr_sel(reg_sel),
    .wr_data(reg_wdata), .out_q(out_q), .dir_q(dir_q), .od_q(od_q), .pol_q(pol_q)
  );

  muxport_strobe #(.W(W), .SYNC_N(2)) u_strobe (
    .clk(clk), .rst_ni(rst_ni), .strobe_i(strobe_a), .pol_i(pol_q),
    .pins_i(pad_in), .latch_q(latch_q)
  );

  muxport_padmux #(.W(W)) u_padmux (
    .clk(clk), .rst_ni(rst_ni), .mode_exp(mode_exp), .bus_e(bus_e), .bus_rw(bus_rw),
    .addr_lo(bus_addr_lo), .wdata(bus_wdata), .out_q(out_q), .dir_q(dir_q),
    .od_q(od_q), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  muxport_busrd #(.W(W)) u_busrd (
    .clk(clk), .rst_ni(rst_ni), .mode_exp(mode_exp), .bus_e(bus_e), .bus_rw(bus_rw),
    .pins_i(pad_in), .rdata_q(bus_rdata)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (sel_e'(reg_sel))
      SEL_PINS:  reg_rdata = pad_in;
      SEL_DIR:   reg_rdata = dir_q;
      SEL_CTRL: begin
        reg_rdata[CTRL_OD_BIT]  = od_q;
        reg_rdata[CTRL_POL_BIT] = pol_q;
      end
      SEL_LATCH: reg_rdata = latch_q;
      default: ;
    endcase
  end

  // R1
  reset_inputs_chk: assert property (@(posedge clk)
    !rst_ni |-> (dir_q == '0 && latch_q == '0 && !od_q));
endmodule

// File: tb/sim_muxport_ctrl.sv
module sim_muxport_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_sel;
  logic       reg_wr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       mode_exp, bus_e, bus_rw, strobe_a;
  logic [7:0] bus_addr_lo, bus_wdata, bus_rdata, pad_in, pad_out, pad_oe;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  muxport_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode_exp(mode_exp),
    .bus_e(bus_e), .bus_rw(bus_rw), .bus_addr_lo(bus_addr_lo),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .strobe_a(strobe_a),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    reg_sel = s;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; reg_sel = 2'd0; reg_wr = 1'b0; reg_wdata = 8'h00;
    mode_exp = 1'b0; bus_e = 1'b0; bus_rw = 1'b1; strobe_a = 1'b0;
    bus_addr_lo = 8'h00; bus_wdata = 8'h00; pad_in = 8'h00;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R1 reset state
    rd(2'd1, v); chk("R1 dir", v, 8'h00);
    rd(2'd2, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd3, v); chk("R1 latch", v, 8'h00);
    chk("R1 oe", pad_oe, 8'h00);

    // R2 register access
    wr(2'd2, 8'hFF); rd(2'd2, v); chk("R2 ctrl mask", v, 8'h03);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h5A); rd(2'd1, v); chk("R2 dir", v, 8'h5A);
    wr(2'd3, 8'hC3); rd(2'd3, v); chk("R2 latch ro", v, 8'h00);

    // R3 / R4 sweep of direction and output patterns, both drive styles
    for (int od = 0; od < 2; od++) begin
      wr(2'd2, 8'(od));
      for (int d = 0; d < 256; d += 5) begin
        logic [7:0] dv, ov;
        dv = 8'(d);
        ov = 8'(d * 37 + 11);
        wr(2'd1, dv);
        wr(2'd0, ov);
        chk(od != 0 ? "R4 out" : "R3 out", pad_out, ov);
        chk(od != 0 ? "R4 oe" : "R3 oe", pad_oe, od != 0 ? (dv & ~ov) : dv);
      end
    end

    // R5 strobe, rising polarity
    wr(2'd2, 8'h02);
    pad_in = 8'hA5; strobe_a = 1'b1; cyc(4);
    rd(2'd3, v); chk("R5 rise load", v, 8'hA5);
    pad_in = 8'h3C; strobe_a = 1'b0; cyc(4);
    rd(2'd3, v); chk("R5 fall ignored", v, 8'hA5);
    // falling polarity
    wr(2'd2, 8'h00);
    pad_in = 8'h0F; strobe_a = 1'b1; cyc(4);
    rd(2'd3, v); chk("R5 rise ignored", v, 8'hA5);
    strobe_a = 1'b0; cyc(4);
    rd(2'd3, v); chk("R5 fall load", v, 8'h0F);

    // R10 live pins versus capture register
    pad_in = 8'h77; cyc(1);
    rd(2'd0, v); chk("R10 live", v, 8'h77);
    rd(2'd3, v); chk("R10 latch kept", v, 8'h0F);

    // R6 R7 R8 R9 expanded bus sweep, open-drain on and off
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'hFF);
    for (int od = 0; od < 2; od++) begin
      wr(2'd2, 8'(od));
      @(negedge clk); mode_exp = 1'b1;
      for (int a = 0; a < 256; a += 7) begin
        logic [7:0] av, dv, prev;
        av = 8'(a); dv = 8'(a * 13 + 3);
        // write cycle
        @(negedge clk); bus_e = 1'b0; bus_rw = 1'b0; bus_addr_lo = av; bus_wdata = dv;
        #1;
        chk(od != 0 ? "R9 addr out" : "R6 addr out", pad_out, av);
        chk(od != 0 ? "R9 addr oe" : "R6 addr oe", pad_oe, 8'hFF);
        @(negedge clk); bus_e = 1'b1; #1;
        chk(od != 0 ? "R9 wdata" : "R7 wdata", pad_out, dv);
        chk(od != 0 ? "R9 woe" : "R7 woe", pad_oe, 8'hFF);
        // read cycle
        prev = bus_rdata;
        @(negedge clk); bus_e = 1'b0; bus_rw = 1'b1; bus_addr_lo = ~av; #1;
        chk("R6 addr rd", pad_out, ~av);
        @(negedge clk); bus_e = 1'b1; pad_in = dv ^ 8'h96; cyc(2);
        chk("R8 oe off", pad_oe, 8'h00);
        chk("R8 hold", bus_rdata, prev);
        @(negedge clk); bus_e = 1'b0; cyc(1);
        chk("R8 rdata", bus_rdata, dv ^ 8'h96);
      end
      @(negedge clk); mode_exp = 1'b0;
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule